// File: doc/BRIEF.md
# Elastic Byte Shift Chain with Overlapped Stages

The block is a multistage shift register built from elastic pipeline stages. Every channel between stages, and the two channels at the block's edge, use a valid/ready handshake. A value moves across a channel on a clock edge where both valid and ready are high. Each stage runs a small repeating loop. A parameter selects the type of stage used for the whole chain.

The overlapped stage has an input register and an output register. It takes a new value from upstream while it offers its output register downstream. When both transfers have completed, in either order, it moves the input register into the output register. By default that move happens on the edge that completes the second transfer. An optional variant spends a separate cycle on the move. The plain stage has a single register and follows a strict loop: it first delivers what it holds, and only then takes a new value. In a chain of plain stages, a freed slot has to walk back toward the input before the chain can accept new data.

All registers clear to zero at reset, and every stage starts by offering that zero. The first DEPTH values out of the chain are therefore empty values, and the data that was fed in follows. The chain is used to compare how the two loop orders limit throughput under the same traffic.

Top module: `elastic_shift_chain`

## Requirements
- R1: The first cycle after reset shows out_valid = 1 and out_data = 0. in_ready = 1 when STAGE_KIND is the overlapped stage, and in_ready = 0 when it is the plain stage.
- R2: The first DEPTH values delivered are zero. After them, the accepted inputs appear in the order they were taken and with their values unchanged.
- R3: A transfer happens on an edge where valid and ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle.
- R4: Once in_ready is high, it stays high until an input is accepted.
- R5: An overlapped chain whose move step is fused (MOVE_CYCLE = 0), with in_valid and out_ready held high from reset, accepts a value and delivers a value on every cycle.
- R6: A plain chain never delivers on two consecutive cycles and never accepts on two consecutive cycles. When it flows freely, it delivers at most one value every two cycles.
- R7: An overlapped chain with a separate move cycle (MOVE_CYCLE = 1) also never delivers or accepts on two consecutive cycles. When it flows freely from reset, it delivers exactly one value every two cycles.
- R8: With out_ready held low from reset, an overlapped chain accepts exactly DEPTH values and then holds in_ready low, while a plain chain accepts none. The number of values held never exceeds 2*DEPTH for the overlapped chain or DEPTH for the plain chain.
- R9: Under the same input and output stall pattern, a fused overlapped chain delivers more values than a plain chain in the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream offers in_data |
| in_ready | output | 1 | First stage can take a value this cycle |
| in_data | input | WIDTH | Value offered to the chain |
| out_valid | output | 1 | Last stage offers out_data |
| out_ready | input | 1 | Downstream takes out_data this cycle |
| out_data | output | WIDTH | Value offered by the last stage |

## Verification
A stage that loses its done flag, or that stays in its move phase, either duplicates a value or drops one. This shows at the output as an ordering mismatch once the affected value reaches the end of the chain, which takes no more than about 2*DEPTH cycles of flow. A stage that moves its registers too early changes the accepted count when the output is stalled, so the fill test catches it within a few DEPTH cycles. A plain stage that overlaps its read and write shows up in the very first free-flow cycles, as back-to-back deliveries.

// File: rtl/shchain_pkg.sv
package shchain_pkg;

   typedef enum logic [0:0] {
      STAGE_PLAIN   = 1'b0,
      STAGE_OVERLAP = 1'b1
   } stage_kind_e;

   typedef enum logic [0:0] {
      PL_EMIT = 1'b0,
      PL_TAKE = 1'b1
   } plain_phase_e;

   typedef enum logic [0:0] {
      OV_XFER = 1'b0,
      OV_MOVE = 1'b1
   } ovl_phase_e;

   function automatic int unsigned stage_capacity(stage_kind_e kind);
      return (kind == STAGE_OVERLAP) ? 2 : 1;
   endfunction

endpackage

// File: rtl/shchain_plain_stage.sv
module shchain_plain_stage
   import shchain_pkg::*;
#(
   parameter int unsigned WIDTH = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [WIDTH-1:0] dn_data
);

   plain_phase_e     phase_q;
   logic [WIDTH-1:0] hold_q;
   logic             take_fire;
   logic             emit_fire;

   always_comb begin
      dn_valid  = (phase_q == PL_EMIT);
      up_ready  = (phase_q == PL_TAKE);
      dn_data   = hold_q;
      emit_fire = dn_valid && dn_ready;
      take_fire = up_valid && up_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PL_EMIT;
         hold_q  <= '0;
      end else begin
         unique case (phase_q)
            PL_EMIT: begin
               if (emit_fire) phase_q <= PL_TAKE;
            end
            PL_TAKE: begin
               if (take_fire) begin
                  hold_q  <= up_data;
                  phase_q <= PL_EMIT;
               end
            end
            default: phase_q <= PL_EMIT;
         endcase
      end
   end

endmodule

// File: rtl/shchain_overlap_stage.sv
module shchain_overlap_stage
   import shchain_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter bit          MOVE_CYCLE = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [WIDTH-1:0] dn_data
);

   logic [WIDTH-1:0] in_reg_q;
   logic [WIDTH-1:0] out_reg_q;
   logic             took_q;
   logic             gave_q;
   logic             xfer_open;
   logic             take_fire;
   logic             give_fire;
   logic             take_done;
   logic             give_done;
   logic             both_done;

   always_comb begin
      up_ready  = xfer_open && !took_q;
      dn_valid  = xfer_open && !gave_q;
      dn_data   = out_reg_q;
      take_fire = up_valid && up_ready;
      give_fire = dn_valid && dn_ready;
      take_done = took_q || take_fire;
      give_done = gave_q || give_fire;
      both_done = take_done && give_done;
   end

   generate
      if (MOVE_CYCLE) begin : g_two_step
         ovl_phase_e phase_q;

         assign xfer_open = (phase_q == OV_XFER);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q   <= OV_XFER;
               in_reg_q  <= '0;
               out_reg_q <= '0;
               took_q    <= 1'b0;
               gave_q    <= 1'b0;
            end else begin
               unique case (phase_q)
                  OV_XFER: begin
                     if (take_fire) in_reg_q <= up_data;
                     if (both_done) begin
                        phase_q <= OV_MOVE;
                        took_q  <= 1'b0;
                        gave_q  <= 1'b0;
                     end else begin
                        took_q <= take_done;
                        gave_q <= give_done;
                     end
                  end
                  OV_MOVE: begin
                     out_reg_q <= in_reg_q;
                     phase_q   <= OV_XFER;
                  end
                  default: phase_q <= OV_XFER;
               endcase
            end
         end
      end else begin : g_fused
         assign xfer_open = 1'b1;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_reg_q  <= '0;
               out_reg_q <= '0;
               took_q    <= 1'b0;
               gave_q    <= 1'b0;
            end else begin
               if (take_fire) in_reg_q <= up_data;
               if (both_done) begin
                  out_reg_q <= take_fire ? up_data : in_reg_q;
                  took_q    <= 1'b0;
                  gave_q    <= 1'b0;
               end else begin
                  took_q <= take_done;
                  gave_q <= give_done;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/elastic_shift_chain.sv
module elastic_shift_chain
   import shchain_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned DEPTH      = 8,
   parameter stage_kind_e STAGE_KIND = STAGE_OVERLAP,
   parameter bit          MOVE_CYCLE = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   localparam int unsigned LINKS = DEPTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("elastic_shift_chain: WIDTH must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("elastic_shift_chain: DEPTH must be at least 1");
      end
      if (MOVE_CYCLE && (STAGE_KIND != STAGE_OVERLAP)) begin : g_bad_move
         $error("elastic_shift_chain: MOVE_CYCLE applies to overlapped stages only");
      end
   endgenerate

   logic [LINKS-1:0] lnk_valid;
   logic [LINKS-1:0] lnk_ready;
   logic [WIDTH-1:0] lnk_data [LINKS];

   assign lnk_valid[0]     = in_valid;
   assign lnk_data[0]      = in_data;
   assign in_ready         = lnk_ready[0];
   assign out_valid        = lnk_valid[DEPTH];
   assign out_data         = lnk_data[DEPTH];
   assign lnk_ready[DEPTH] = out_ready;

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (STAGE_KIND == STAGE_OVERLAP) begin : g_ovl
            shchain_overlap_stage #(
               .WIDTH      (WIDTH),
               .MOVE_CYCLE (MOVE_CYCLE)
            ) u_stage (
               .clk      (clk),
               .rst_n    (rst_n),
               .up_valid (lnk_valid[s]),
               .up_ready (lnk_ready[s]),
               .up_data  (lnk_data[s]),
               .dn_valid (lnk_valid[s+1]),
               .dn_ready (lnk_ready[s+1]),
               .dn_data  (lnk_data[s+1])
            );
         end else begin : g_pln
            shchain_plain_stage #(
               .WIDTH (WIDTH)
            ) u_stage (
               .clk      (clk),
               .rst_n    (rst_n),
               .up_valid (lnk_valid[s]),
               .up_ready (lnk_ready[s]),
               .up_data  (lnk_data[s]),
               .dn_valid (lnk_valid[s+1]),
               .dn_ready (lnk_ready[s+1]),
               .dn_data  (lnk_data[s+1])
            );
         end
      end
   endgenerate

endmodule

// File: rtl/elastic_shift_chain_chk.sv
module elastic_shift_chain_chk
   import shchain_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned DEPTH      = 8,
   parameter stage_kind_e STAGE_KIND = STAGE_OVERLAP,
   parameter bit          MOVE_CYCLE = 1'b0
)(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [WIDTH-1:0] out_data
);

   localparam int unsigned CAP         = DEPTH * stage_capacity(STAGE_KIND);
   localparam int unsigned OCC_W       = $clog2(2 * DEPTH + 2) + 1;
   localparam bit          PAIRED      = (STAGE_KIND == STAGE_PLAIN) || MOVE_CYCLE;
   localparam bit          ENTRY_READY = (STAGE_KIND == STAGE_OVERLAP);

   logic [OCC_W-1:0] occ_q;
   logic             in_fire;
   logic             out_fire;

   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ_q <= OCC_W'(DEPTH);
      else        occ_q <= occ_q + OCC_W'(in_fire) - OCC_W'(out_fire);
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_valid && (out_data == '0) && (in_ready == ENTRY_READY)));

   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire |-> (occ_q != '0));

   assert_hold_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_entry_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> in_ready);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(CAP));

   generate
      if (PAIRED) begin : g_paired
         // R6 for plain chains, R7 for two-step overlapped chains
         assert_out_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_fire |=> !out_valid);
         assert_in_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_fire |=> !in_ready);
      end
   endgenerate

endmodule

bind elastic_shift_chain elastic_shift_chain_chk #(
   .WIDTH      (WIDTH),
   .DEPTH      (DEPTH),
   .STAGE_KIND (STAGE_KIND),
   .MOVE_CYCLE (MOVE_CYCLE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/elastic_shift_chain_test.sv
`timescale 1ns/1ps
module elastic_shift_chain_test;
   import shchain_pkg::*;

   localparam int D = 8;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_valid [3];
   logic       src_ready [3];
   logic [7:0] src_data  [3];
   logic       snk_valid [3];
   logic       snk_ready [3];
   logic [7:0] snk_data  [3];

   int checks = 0;
   int fails  = 0;

   int          sent, got, oerr, herr, rerr, orun, irun, max_orun, max_irun;
   int          tput [3];
   logic [7:0]  bad_act, bad_exp;
   logic        stall_prev, rdy_prev;
   logic [7:0]  data_prev;
   logic [31:0] lfsr;

   always #4 clk = ~clk;

   // dut 0: fused overlapped, dut 1: plain, dut 2: overlapped with move cycle
   elastic_shift_chain #(.WIDTH(8), .DEPTH(D), .STAGE_KIND(STAGE_OVERLAP), .MOVE_CYCLE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(src_valid[0]), .in_ready(src_ready[0]), .in_data(src_data[0]),
      .out_valid(snk_valid[0]), .out_ready(snk_ready[0]), .out_data(snk_data[0]));

   elastic_shift_chain #(.WIDTH(8), .DEPTH(D), .STAGE_KIND(STAGE_PLAIN), .MOVE_CYCLE(1'b0)) uut_plain (
      .clk(clk), .rst_n(rst_n),
      .in_valid(src_valid[1]), .in_ready(src_ready[1]), .in_data(src_data[1]),
      .out_valid(snk_valid[1]), .out_ready(snk_ready[1]), .out_data(snk_data[1]));

   elastic_shift_chain #(.WIDTH(8), .DEPTH(D), .STAGE_KIND(STAGE_OVERLAP), .MOVE_CYCLE(1'b1)) uut_slow (
      .clk(clk), .rst_n(rst_n),
      .in_valid(src_valid[2]), .in_ready(src_ready[2]), .in_data(src_data[2]),
      .out_valid(snk_valid[2]), .out_ready(snk_ready[2]), .out_data(snk_data[2]));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      for (int d = 0; d < 3; d++) begin
         src_valid[d] = 1'b0;
         src_data[d]  = 8'd0;
         snk_ready[d] = 1'b0;
      end
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic scen_init(input logic [31:0] seed);
      sent = 0; got = 0; oerr = 0; herr = 0; rerr = 0;
      orun = 0; irun = 0; max_orun = 0; max_irun = 0;
      stall_prev = 1'b0; rdy_prev = 1'b0; data_prev = 8'd0;
      bad_act = 8'd0; bad_exp = 8'd0;
      lfsr = seed;
   endtask

   // mode 0: free flow, 1: output stalled, 2: pseudo-random stalls, 3: drain
   task automatic drive(input int d, input int ncyc, input int mode);
      logic v, r, infire, outfire;
      logic [7:0] expv;
      for (int c = 0; c < ncyc; c++) begin
         unique case (mode)
            0:       begin v = 1'b1; r = 1'b1; end
            1:       begin v = 1'b1; r = 1'b0; end
            2:       begin v = lfsr[0] | lfsr[3]; r = lfsr[1] | lfsr[5]; end
            default: begin v = 1'b0; r = 1'b1; end
         endcase
         src_valid[d] = v;
         snk_ready[d] = r;
         src_data[d]  = 8'(sent + 1);
         #1;
         if (stall_prev && !(snk_valid[d] && snk_data[d] == data_prev)) herr++;
         if (rdy_prev && !src_ready[d]) rerr++;
         infire  = src_valid[d] && src_ready[d];
         outfire = snk_valid[d] && snk_ready[d];
         if (outfire) begin
            expv = (got < D) ? 8'd0 : 8'(got - D + 1);
            if (snk_data[d] != expv) begin
               if (oerr == 0) begin bad_act = snk_data[d]; bad_exp = expv; end
               oerr++;
            end
            got++;
            orun++;
         end else orun = 0;
         if (infire) begin sent++; irun++; end else irun = 0;
         if (orun > max_orun) max_orun = orun;
         if (irun > max_irun) max_irun = irun;
         stall_prev = snk_valid[d] && !snk_ready[d];
         data_prev  = snk_data[d];
         rdy_prev   = src_ready[d] && !src_valid[d];
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         @(negedge clk);
      end
      src_valid[d] = 1'b0;
      snk_ready[d] = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      for (int d = 0; d < 3; d++) begin
         check(snk_valid[d] && snk_data[d] == 8'd0, "R1", $sformatf("dut%0d reset output", d),
               int'(snk_data[d]) + (snk_valid[d] ? 0 : 1000), 0);
         check(src_ready[d] == (d != 1), "R1", $sformatf("dut%0d reset in_ready", d),
               int'(src_ready[d]), (d != 1) ? 1 : 0);
      end
   endtask

   task automatic t_free(input int d);
      do_reset();
      scen_init(32'h1);
      drive(d, 40, 0);
      check(oerr == 0, "R2", $sformatf("dut%0d free-flow order", d), bad_act, bad_exp);
      if (d == 0) begin
         check(got == 40 && sent == 40, "R5", "fused delivers and accepts every cycle", got + sent, 80);
      end else if (d == 1) begin
         check(max_orun == 1 && max_irun == 1, "R6", "plain back-to-back transfers",
               max_orun * 10 + max_irun, 11);
         check(got <= 20 && got >= 16, "R6", "plain free-flow deliveries in 40 cycles", got, 20);
      end else begin
         check(max_orun == 1 && max_irun == 1, "R7", "two-step back-to-back transfers",
               max_orun * 10 + max_irun, 11);
         check(got == 20, "R7", "two-step free-flow deliveries in 40 cycles", got, 20);
      end
   endtask

   task automatic t_fill(input int d);
      int exp_acc;
      do_reset();
      scen_init(32'h2);
      drive(d, 4 * D + 4, 1);
      exp_acc = (d == 1) ? 0 : D;
      check(sent == exp_acc, "R8", $sformatf("dut%0d accepted with output stalled", d), sent, exp_acc);
      check(herr == 0, "R3", $sformatf("dut%0d stalled output held", d), herr, 0);
      drive(d, 6 * D + 8, 3);
      check(got == D + exp_acc, "R2", $sformatf("dut%0d drained count", d), got, D + exp_acc);
      check(oerr == 0, "R2", $sformatf("dut%0d drained order", d), bad_act, bad_exp);
   endtask

   task automatic t_random(input int d);
      do_reset();
      scen_init(32'hACE1_2357);
      drive(d, 300, 2);
      tput[d] = got;
      drive(d, 8 * D, 3);
      check(oerr == 0, "R2", $sformatf("dut%0d random-stall order", d), bad_act, bad_exp);
      check(got == sent + D, "R2", $sformatf("dut%0d all values emerged", d), got, sent + D);
      check(herr == 0, "R3", $sformatf("dut%0d output held under stalls", d), herr, 0);
      check(rerr == 0, "R4", $sformatf("dut%0d entry ready held", d), rerr, 0);
   endtask

   task automatic t_compare();
      check(tput[0] > tput[1], "R9", "fused overlapped beats plain under same stalls",
            tput[0], tput[1] + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int d = 0; d < 3; d++) begin
         src_valid[d] = 1'b0;
         src_data[d]  = 8'd0;
         snk_ready[d] = 1'b0;
      end
      t_reset();
      for (int d = 0; d < 3; d++) t_free(d);
      for (int d = 0; d < 3; d++) t_fill(d);
      for (int d = 0; d < 3; d++) t_random(d);
      t_compare();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule